// File: doc/BRIEF.md
# DC Offset Calibration Averager

This block measures the DC level of a signed sample stream. A calibration is started with a one-clock request. The block then adds up the next N valid samples, where N is the cycle count supplied at the start. It divides the sum by N with a sequential restoring divider that produces one quotient bit per clock. The resulting mean is loaded into a 24-bit two's-complement offset register. In that register the binary point sits directly right of the sign bit, so the register spans -1.0 up to one LSB below +1.0.

When the register holds the new mean, a one-clock data-ready pulse marks the end of the calibration. A busy flag is high from the clock after the request until that pulse. The host can read the register at any time and can write it, so a stored offset can be put back later. Sample width and count width are parameters.

Top module: `dc_offset_cal`

## Requirements
- R1: After reset the offset register reads 0 (0.0), busy is 0 and data-ready is 0.
- R2: A host write loads reg_wdata into the register, and reg_rdata shows it on the next clock. This also holds while a calibration runs, unless the result is written in the same clock.
- R3: A start request taken while idle raises busy on the next clock. Busy stays high until the data-ready cycle and is low in that cycle.
- R4: The register receives the mean of the first N samples that have smp_valid high, counted from the clock after the request. The mean is the sum divided by N, truncated toward zero, written as two's complement. Clocks with smp_valid low are skipped.
- R5: A cycle count of 0 is treated as 1.
- R6: The cycle count is captured when the request is taken, so later changes to cyc_count during the calibration have no effect on the result.
- R7: A start request while busy is ignored: the running calibration finishes with the result set by its own samples.
- R8: Data-ready is high for exactly one clock, and in that clock reg_rdata already holds the new mean.
- R9: The sum cannot overflow. N samples all at full-scale positive give full-scale positive, and N samples all at full-scale negative give full-scale negative, at the largest N.
- R10: Valid samples that arrive after the Nth accepted one, while the mean is being computed, do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed sample |
| cal_start | input | 1 | Calibration request pulse |
| cyc_count | input | CNT_W | Samples per calibration (0 means 1) |
| reg_wr | input | 1 | Host write enable for the offset register |
| reg_wdata | input | SAMPLE_W | Host write data |
| reg_rdata | output | SAMPLE_W | Offset register contents |
| busy | output | 1 | Calibration in progress |
| drdy | output | 1 | One-clock pulse when the result is loaded |

## Verification
The bench builds the block with 8-bit samples and a 4-bit cycle count. With these sizes every N from 0 to 15 can be swept against six sample patterns in one short run. The small widths bring the largest N and both full-scale extremes within reach. They also expose the truncation of small negative means, where the -1/0/1 patterns show rounding toward zero. During each run the bench moves cyc_count after the start, fires extra requests and strobes junk samples during the divide, so the capture and ignore rules are checked on every configuration.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_DIV  = 2'd2
    } cal_state_e;

    function automatic int acc_bits(input int sample_w, input int cnt_w);
        return sample_w + cnt_w;
    endfunction

    function automatic int step_bits(input int acc_w);
        return $clog2(acc_w + 1);
    endfunction

endpackage

// File: rtl/dcc_accum.sv
module dcc_accum #(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 24,
    localparam int ACC_W   = dcc_pkg::acc_bits(SAMPLE_W, CNT_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                en,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [ACC_W-1:0]    sum,
    output logic [CNT_W-1:0]    count
);

    logic [ACC_W-1:0] sample_ext;

    assign sample_ext = {{CNT_W{sample[SAMPLE_W-1]}}, sample};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum   <= '0;
            count <= '0;
        end else if (en) begin
            sum   <= sum + sample_ext;
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/dcc_divider.sv
module dcc_divider #(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 24,
    localparam int ACC_W   = dcc_pkg::acc_bits(SAMPLE_W, CNT_W),
    localparam int STEP_W  = dcc_pkg::step_bits(ACC_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [ACC_W-1:0]    dividend,
    input  logic [CNT_W-1:0]    divisor,
    output logic [SAMPLE_W-1:0] mean,
    output logic                done
);

    logic [ACC_W-1:0]  work_q;
    logic [CNT_W-1:0]  rem_q;
    logic [CNT_W-1:0]  dsr_q;
    logic              neg_q;
    logic [STEP_W-1:0] steps_q;
    logic              done_q;

    logic [CNT_W:0]    trial;
    logic [CNT_W:0]    diff;
    logic              fits;
    logic [SAMPLE_W:0] mag;
    logic [SAMPLE_W:0] signed_q;

    assign trial = {rem_q, work_q[ACC_W-1]};
    assign diff  = trial - {1'b0, dsr_q};
    assign fits  = trial >= {1'b0, dsr_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q  <= '0;
            rem_q   <= '0;
            dsr_q   <= '0;
            neg_q   <= 1'b0;
            steps_q <= '0;
            done_q  <= 1'b0;
        end else if (start) begin
            neg_q   <= dividend[ACC_W-1];
            work_q  <= dividend[ACC_W-1] ? (~dividend + 1'b1) : dividend;
            rem_q   <= '0;
            dsr_q   <= divisor;
            steps_q <= STEP_W'(ACC_W);
            done_q  <= 1'b0;
        end else if (steps_q != '0) begin
            if (fits) begin
                rem_q  <= diff[CNT_W-1:0];
                work_q <= {work_q[ACC_W-2:0], 1'b1};
            end else begin
                rem_q  <= trial[CNT_W-1:0];
                work_q <= {work_q[ACC_W-2:0], 1'b0};
            end
            steps_q <= steps_q - 1'b1;
            done_q  <= (steps_q == STEP_W'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign mag      = work_q[SAMPLE_W:0];
    assign signed_q = neg_q ? (~mag + 1'b1) : mag;
    assign mean     = signed_q[SAMPLE_W-1:0];
    assign done     = done_q;

    // R4
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (rst)
        (steps_q != '0) |-> (rem_q < dsr_q));

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (steps_q == '0));

endmodule

// File: rtl/dcc_offset_reg.sv
module dcc_offset_reg #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cal_wr,
    input  logic [SAMPLE_W-1:0] cal_val,
    input  logic                host_wr,
    input  logic [SAMPLE_W-1:0] host_val,
    output logic [SAMPLE_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (cal_wr) begin
            q <= cal_val;
        end else if (host_wr) begin
            q <= host_val;
        end
    end

    // R2
    host_write_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !cal_wr) |=> (q == $past(host_val)));

    // R8
    cal_write_chk: assert property (@(posedge clk) disable iff (rst)
        cal_wr |=> (q == $past(cal_val)));

endmodule

// File: rtl/dc_offset_cal.sv
module dc_offset_cal #(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                cal_start,
    input  logic [CNT_W-1:0]    cyc_count,
    input  logic                reg_wr,
    input  logic [SAMPLE_W-1:0] reg_wdata,
    output logic [SAMPLE_W-1:0] reg_rdata,
    output logic                busy,
    output logic                drdy
);
    import dcc_pkg::*;

    localparam int ACC_W = acc_bits(SAMPLE_W, CNT_W);

    cal_state_e           state_q;
    logic [CNT_W-1:0]     n_q;
    logic                 drdy_q;
    logic [ACC_W-1:0]     sum;
    logic [CNT_W-1:0]     count;
    logic [SAMPLE_W-1:0]  mean;
    logic                 div_done;
    logic                 start_ok;
    logic                 acc_full;
    logic                 acc_en;
    logic                 div_start;
    logic                 result_wr;

    assign start_ok  = cal_start && (state_q == ST_IDLE);
    assign acc_full  = (count == n_q);
    assign acc_en    = (state_q == ST_ACC) && smp_valid && !acc_full;
    assign div_start = (state_q == ST_ACC) && acc_full;
    assign result_wr = (state_q == ST_DIV) && div_done;

    dcc_accum #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .clr    (start_ok),
        .en     (acc_en),
        .sample (smp_data),
        .sum    (sum),
        .count  (count)
    );

    dcc_divider #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (sum),
        .divisor  (n_q),
        .mean     (mean),
        .done     (div_done)
    );

    dcc_offset_reg #(.SAMPLE_W(SAMPLE_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .cal_wr   (result_wr),
        .cal_val  (mean),
        .host_wr  (reg_wr),
        .host_val (reg_wdata),
        .q        (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            n_q     <= CNT_W'(1);
            drdy_q  <= 1'b0;
        end else begin
            drdy_q <= result_wr;
            unique case (state_q)
                ST_IDLE: if (start_ok) begin
                    state_q <= ST_ACC;
                    n_q     <= (cyc_count == '0) ? CNT_W'(1) : cyc_count;
                end
                ST_ACC:  if (acc_full) state_q <= ST_DIV;
                ST_DIV:  if (div_done) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign drdy = drdy_q;

    // R8
    drdy_single_chk: assert property (@(posedge clk) disable iff (rst)
        drdy |=> !drdy);

    // R3
    busy_drdy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        drdy |-> !busy);

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (count <= n_q));

    // R6
    n_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(n_q));

    // R5
    n_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        n_q != '0);

endmodule

// File: tb/dc_offset_cal_test.sv
module dc_offset_cal_test;

    localparam int SW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          cal_start = 1'b0;
    logic [CW-1:0] cyc_count = '0;
    logic          reg_wr = 1'b0;
    logic [SW-1:0] reg_wdata = '0;
    logic [SW-1:0] reg_rdata;
    logic          busy;
    logic          drdy;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;

    dc_offset_cal #(.SAMPLE_W(SW), .CNT_W(CW)) uut (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .cal_start (cal_start),
        .cyc_count (cyc_count),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .drdy      (drdy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    endtask

    function automatic int pat_val(input int p, input int i);
        case (p)
            0: return 127;
            1: return -128;
            2: return i * 13 - 90;
            3: return (i % 2 == 0) ? i * 9 : -(i * 9 + 1);
            4: return -1;
            default: return (i % 3) - 1;
        endcase
    endfunction

    task automatic run_cal(input int n_cfg, input int p);
        int neff;
        int sum;
        int expv;
        int waited;
        bit busy_ok;
        neff = (n_cfg == 0) ? 1 : n_cfg;
        sum = 0;
        @(negedge clk);
        cal_start = 1'b1;
        cyc_count = CW'(n_cfg);
        @(negedge clk);
        cal_start = 1'b0;
        check(busy == 1'b1, "R3 busy after start", int'(busy), 1);
        for (int i = 0; i < neff; i++) begin
            smp_valid = 1'b1;
            smp_data  = SW'(pat_val(p, i));
            sum += pat_val(p, i);
            @(negedge clk);
            if (i == 0) cyc_count = CW'(15 - n_cfg);   // R6: change after capture
            if (i % 3 == 1) begin                       // R4: idle gap skipped
                smp_valid = 1'b0;
                smp_data  = 8'h63;
                @(negedge clk);
            end
        end
        // R10 junk samples and R7 stray request while busy
        smp_valid = 1'b1;
        smp_data  = 8'h7F;
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        smp_data  = 8'h80;
        expv = sum / neff;
        waited = 0;
        busy_ok = 1'b1;
        while (!drdy && waited < 100) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            waited++;
        end
        smp_valid = 1'b0;
        check(drdy == 1'b1, "R8 drdy seen", int'(drdy), 1);
        check(busy_ok, "R3 busy held until drdy", int'(busy_ok), 1);
        check(busy == 1'b0, "R3 busy low in drdy cycle", int'(busy), 0);
        check(int'($signed(reg_rdata)) == expv,
              (p < 2 && n_cfg == 15) ? "R9 extreme mean" :
              (n_cfg == 0) ? "R5 zero count mean" : "R4 R6 R7 R10 mean",
              int'($signed(reg_rdata)), expv);
        @(negedge clk);
        check(drdy == 1'b0, "R8 drdy one cycle", int'(drdy), 0);
        check(busy == 1'b0, "R7 no restart", int'(busy), 0);
        check(int'($signed(reg_rdata)) == expv, "R8 value held", int'($signed(reg_rdata)), expv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(reg_rdata == '0, "R1 register reset", int'(reg_rdata), 0);
        check(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        check(drdy == 1'b0, "R1 drdy reset", int'(drdy), 0);

        for (int v = -128; v < 128; v += 37) begin
            reg_wr = 1'b1;
            reg_wdata = SW'(v);
            @(negedge clk);
            reg_wr = 1'b0;
            check(int'($signed(reg_rdata)) == v, "R2 host write", int'($signed(reg_rdata)), v);
        end

        for (int n = 0; n < 16; n++)
            for (int p = 0; p < 6; p++)
                run_cal(n, p);

        // R2 write during a calibration is visible at once
        @(negedge clk);
        cal_start = 1'b1;
        cyc_count = 4'd3;
        @(negedge clk);
        cal_start = 1'b0;
        reg_wr = 1'b1;
        reg_wdata = 8'h5A;
        @(negedge clk);
        reg_wr = 1'b0;
        check(reg_rdata == 8'h5A, "R2 write while busy", int'(reg_rdata), 'h5A);
        for (int i = 0; i < 3; i++) begin
            smp_valid = 1'b1;
            smp_data  = 8'd6;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        for (int w = 0; w < 100 && !drdy; w++) @(negedge clk);
        check(reg_rdata == 8'd6, "R4 result after host write", int'(reg_rdata), 6);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule